// File: doc/BRIEF.md
# Prescaled Watchdog Reset Generator

This block resets the system when software stops servicing it. A free-running prescaler, clocked by the crystal clock, feeds a short watchdog counter. The two form one long count chain. When that chain reaches its terminal value, the block drives a reset pulse of fixed width. It also sets a sticky flag that records the watchdog as the cause of the reset. The configuration selects one of two timeout lengths.

Software services the block by writing to a decoded address. A service clears the watchdog counter and the upper prescaler stages. The lowest four prescaler stages keep counting, so a service can shorten the next timeout by up to fifteen cycles. Reading the control location returns a fixed byte, the low byte of the reset vector, and changes no state. A stop instruction, an internal reset and the power-on sequence each clear part or all of the chain. A test/monitor input blocks the reset output entirely.

Top module: `wdog_chain`

## Requirements
- R1: While `por_i` is high, `rst_o` and `cause_o` are 0 one clock edge later, and all counters are cleared.
- R2: After `por_i` falls, the prescaler runs for `POR_DLY` edges (4096). It is then cleared at that edge. The watchdog counter is held at zero during this window. With the short rate, `rst_o` rises on edge `POR_DLY + 8177` after the release.
- R3: With `rate_long_i` = 0 and the chain at zero, `rst_o` rises on edge `2^(PRE_W+SHORT_BITS) - 2^LOW_KEEP + 1` (8177 with defaults).
- R4: With `rate_long_i` = 1 and the chain at zero, `rst_o` rises on edge `2^(PRE_W+WD_W) - 2^LOW_KEEP + 1`. This is 262129 with defaults and 65521 when `WD_W` = 4.
- R5: A `svc_wr_i` pulse clears the watchdog counter and prescaler bits `PRE_W-1..LOW_KEEP` (11..4). Bits 3..0 keep counting. Let m be the edge that samples the service, counted from a zeroed chain. In short mode, `rst_o` then rises on edge `m - (m mod 16) + 8177`.
- R6: `rst_o` stays high for exactly `PULSE_LEN` (32) edges. The chain is held at zero while it is high, so counting restarts from zero at the edge where `rst_o` falls.
- R7: `cause_o` is set on the edge where `rst_o` rises. Only `por_i` clears it. Internal resets and later timeouts leave it at 1.
- R8: While `ctl_rd_i` = 1, `rd_data_o` equals `VEC_LO`; otherwise `rd_data_o` is 0. A read has no effect on the timeout.
- R9: A `stop_i` pulse clears the whole prescaler and leaves the watchdog counter unchanged. A stop at edge 5000 after a zeroed chain gives a rise on edge 9081 in short mode.
- R10: An `int_rst_i` pulse clears the prescaler and the watchdog counter. An internal reset at edge 100 gives a rise on edge 8277 in short mode.
- R11: While `test_dis_i` = 1, `rst_o` never rises.
- R12: A service sampled on the same edge at which the terminal count would start the pulse wins. No pulse is issued, and the chain restarts with its low nibble at (m mod 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| int_rst_i | input | 1 | Internal reset pulse; clears both counters |
| stop_i | input | 1 | Stop-instruction pulse; clears the prescaler |
| test_dis_i | input | 1 | Test/monitor disable; blocks the reset output |
| rate_long_i | input | 1 | Timeout select: 1 long, 0 short |
| svc_wr_i | input | 1 | Decoded write strobe to the service address |
| ctl_rd_i | input | 1 | Decoded read strobe for the control location |
| rd_data_o | output | DATA_W | Read data: `VEC_LO` during a read, else 0 |
| rst_o | output | 1 | Watchdog reset pulse, active high |
| cause_o | output | 1 | Sticky watchdog reset-cause flag |

## Verification
The bench places service writes at chain positions that are not multiples of sixteen. A design that also cleared the low prescaler stages would fire up to fifteen cycles late. One service lands exactly on the terminal count. A design without service priority would still emit a pulse there. A stop pulse is issued after the watchdog counter has already advanced. A design that cleared the watchdog counter on stop would time out a full prescaler period too late. The bench also checks the power-on window, the long rate, internal reset, the disable input and read side effects. Each of these would show up as a shifted or missing `rst_o` edge.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
   // Clear requests for the prescaler: whole chain, or only the stages above the kept low bits
   typedef struct packed {
      logic all;
      logic upper;
   } pre_clr_t;
endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler
   import wdog_pkg::*;
#(
   parameter int PRE_W    = 12,
   parameter int LOW_KEEP = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  pre_clr_t         clr_i,
   output logic [PRE_W-1:0] cnt_o,
   output logic             carry_o
);
   localparam int HI_W = PRE_W - LOW_KEEP;
   localparam logic [LOW_KEEP-1:0] LOW_ONE = LOW_KEEP'(1);
   localparam logic [HI_W-1:0]     HI_ONE  = HI_W'(1);

   generate
      if (LOW_KEEP < 1 || HI_W < 1) begin : g_bad_split
         $error("wdog_prescaler: LOW_KEEP must lie in 1..PRE_W-1");
      end
   endgenerate

   logic [LOW_KEEP-1:0] low_q;
   logic [HI_W-1:0]     hi_q;
   logic                low_wrap;

   assign low_wrap = &low_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i.all) begin
         low_q <= '0;
         hi_q  <= '0;
      end else begin
         low_q <= low_q + LOW_ONE;
         if (clr_i.upper) begin
            hi_q <= '0;
         end else if (low_wrap) begin
            hi_q <= hi_q + HI_ONE;
         end
      end
   end

   assign cnt_o   = {hi_q, low_q};
   assign carry_o = low_wrap & (&hi_q);

   p_svc_upper_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i.upper && !clr_i.all |=> hi_q == '0);
   p_svc_low_runs_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i.upper && !clr_i.all |=> low_q == $past(low_q) + LOW_ONE);
   p_full_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i.all |=> cnt_o == '0);
endmodule

// File: rtl/wdog_wd_counter.sv
`timescale 1ns/1ps
module wdog_wd_counter #(
   parameter int WD_W       = 6,
   parameter int SHORT_BITS = 1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic inc_i,
   input  logic long_sel_i,
   output logic full_o
);
   localparam logic [WD_W-1:0] WD_ONE = WD_W'(1);

   generate
      if (SHORT_BITS < 0 || SHORT_BITS >= WD_W) begin : g_bad_tap
         $error("wdog_wd_counter: SHORT_BITS must lie in 0..WD_W-1");
      end
   endgenerate

   logic [WD_W-1:0] cnt_q;
   logic            short_full;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + WD_ONE;
      end
   end

   // Short tap: a zero-width tap leaves the prescaler alone to set the period
   generate
      if (SHORT_BITS == 0) begin : g_tap_none
         assign short_full = 1'b1;
      end else begin : g_tap_bits
         assign short_full = &cnt_q[SHORT_BITS-1:0];
      end
   endgenerate

   assign full_o = long_sel_i ? (&cnt_q) : short_full;

   p_wd_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      inc_i && !clr_i |=> cnt_q == $past(cnt_q) + WD_ONE);
   p_wd_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !inc_i && !clr_i |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_por_window.sv
`timescale 1ns/1ps
module wdog_por_window #(
   parameter int POR_DLY = 4096
) (
   input  logic clk_i,
   input  logic por_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(POR_DLY + 1);
   localparam logic [CW-1:0] LAST   = CW'(POR_DLY - 1);
   localparam logic [CW-1:0] CW_ONE = CW'(1);

   generate
      if (POR_DLY < 1) begin : g_bad_dly
         $error("wdog_por_window: POR_DLY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CW_ONE;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == LAST);

   p_window_end_r2: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(busy_q) |-> $past(cnt_q) == LAST);
   p_window_once_r2: assert property (@(posedge clk_i) disable iff (por_i)
      !busy_q |=> !busy_q);
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
   parameter int PULSE_LEN = 32
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic fire_i,
   output logic active_o
);
   localparam int CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
   localparam logic [CW-1:0] LAST   = CW'(PULSE_LEN - 1);
   localparam logic [CW-1:0] CW_ONE = CW'(1);

   generate
      if (PULSE_LEN < 2) begin : g_bad_len
         $error("wdog_pulse: PULSE_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          act_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (act_q) begin
         if (cnt_q == LAST) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW_ONE;
         end
      end else if (fire_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end
   end

   assign active_o = act_q;

   p_pulse_start_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      fire_i && !act_q |=> act_q && cnt_q == '0);
   p_pulse_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      act_q && cnt_q != LAST |=> act_q);
   p_pulse_end_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(act_q) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/wdog_chain.sv
`timescale 1ns/1ps
module wdog_chain
   import wdog_pkg::*;
#(
   parameter int PRE_W      = 12,
   parameter int LOW_KEEP   = 4,
   parameter int WD_W       = 6,
   parameter int SHORT_BITS = 1,
   parameter int PULSE_LEN  = 32,
   parameter int POR_DLY    = 4096,
   parameter int DATA_W     = 8,
   parameter logic [DATA_W-1:0] VEC_LO = 8'hC4
) (
   input  logic              clk_i,
   input  logic              por_i,
   input  logic              int_rst_i,
   input  logic              stop_i,
   input  logic              test_dis_i,
   input  logic              rate_long_i,
   input  logic              svc_wr_i,
   input  logic              ctl_rd_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rst_o,
   output logic              cause_o
);
   generate
      if (PRE_W <= LOW_KEEP) begin : g_bad_pre
         $error("wdog_chain: PRE_W must exceed LOW_KEEP");
      end
      if (SHORT_BITS >= WD_W) begin : g_bad_short
         $error("wdog_chain: SHORT_BITS must be below WD_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("wdog_chain: DATA_W must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] pre_cnt;
   logic             pre_carry;
   pre_clr_t         pre_clr;
   logic             wd_clr;
   logic             wd_inc;
   logic             wd_full;
   logic             win_busy;
   logic             win_done;
   logic             pulse_act;
   logic             term_hit;
   logic             fire;
   logic             cause_q;

   // Clear routing: service trims the chain, every other source zeroes the prescaler
   always_comb begin
      pre_clr.all   = int_rst_i | stop_i | pulse_act | win_done;
      pre_clr.upper = svc_wr_i;
   end

   assign wd_clr = int_rst_i | pulse_act | svc_wr_i | win_busy;
   assign wd_inc = pre_carry & ~stop_i;

   wdog_por_window #(
      .POR_DLY (POR_DLY)
   ) u_por_win (
      .clk_i  (clk_i),
      .por_i  (por_i),
      .busy_o (win_busy),
      .done_o (win_done)
   );

   wdog_prescaler #(
      .PRE_W    (PRE_W),
      .LOW_KEEP (LOW_KEEP)
   ) u_pre (
      .clk_i   (clk_i),
      .rst_i   (por_i),
      .clr_i   (pre_clr),
      .cnt_o   (pre_cnt),
      .carry_o (pre_carry)
   );

   wdog_wd_counter #(
      .WD_W       (WD_W),
      .SHORT_BITS (SHORT_BITS)
   ) u_wd (
      .clk_i      (clk_i),
      .rst_i      (por_i),
      .clr_i      (wd_clr),
      .inc_i      (wd_inc),
      .long_sel_i (rate_long_i),
      .full_o     (wd_full)
   );

   // Terminal value: tap full, upper prescaler all ones, kept low stages at zero
   assign term_hit = wd_full
                   & (&pre_cnt[PRE_W-1:LOW_KEEP])
                   & (pre_cnt[LOW_KEEP-1:0] == '0);

   assign fire = term_hit & ~test_dis_i & ~svc_wr_i & ~int_rst_i
               & ~win_busy & ~pulse_act;

   wdog_pulse #(
      .PULSE_LEN (PULSE_LEN)
   ) u_pulse (
      .clk_i    (clk_i),
      .rst_i    (por_i),
      .fire_i   (fire),
      .active_o (pulse_act)
   );

   always_ff @(posedge clk_i) begin
      if (por_i) begin
         cause_q <= 1'b0;
      end else if (fire) begin
         cause_q <= 1'b1;
      end
   end

   assign rst_o     = pulse_act;
   assign cause_o   = cause_q;
   assign rd_data_o = ctl_rd_i ? VEC_LO : '0;

   p_por_quiet_r1: assert property (@(posedge clk_i)
      por_i |=> !rst_o && !cause_o);
   p_window_quiet_r2: assert property (@(posedge clk_i) disable iff (por_i)
      win_busy && !rst_o |=> !rst_o);
   p_cause_on_rise_r7: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(rst_o) |-> cause_o);
   p_cause_sticky_r7: assert property (@(posedge clk_i) disable iff (por_i)
      cause_o |=> cause_o);
   p_int_rst_blocks_r10: assert property (@(posedge clk_i) disable iff (por_i)
      int_rst_i && !rst_o |=> !rst_o);
   p_disable_blocks_r11: assert property (@(posedge clk_i) disable iff (por_i)
      test_dis_i && !rst_o |=> !rst_o);
   p_svc_wins_r12: assert property (@(posedge clk_i) disable iff (por_i)
      svc_wr_i && !rst_o |=> !rst_o);
endmodule

// File: tb/test_wdog_chain.sv
`timescale 1ns/1ps
module test_wdog_chain;
   localparam int PRE_W = 12;
   localparam int LOW_KEEP = 4;
   localparam int WD_W = 4;
   localparam int SHORT_BITS = 1;
   localparam int PULSE_LEN = 32;
   localparam int POR_DLY = 4096;
   localparam logic [7:0] VEC = 8'hC4;
   localparam int T_S = (1 << (PRE_W + SHORT_BITS)) - (1 << LOW_KEEP);
   localparam int T_L = (1 << (PRE_W + WD_W)) - (1 << LOW_KEEP);

   typedef struct packed {
      logic rate;
      int   svc;
      int   stp;
      int   irst;
      int   rd;
      int   expd;
      int   rq;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 0,    0,    0,   0,  T_S + 1,                      3},  // R3 short
      '{1'b1, 0,    0,    0,   0,  T_L + 1,                      4},  // R4 long
      '{1'b0, 1000, 0,    0,   0,  1000 - (1000 % 16) + T_S + 1, 5},  // R5 unaligned service
      '{1'b0, 8175, 0,    0,   0,  8175 - (8175 % 16) + T_S + 1, 5},  // R5 late service
      '{1'b0, 8177, 0,    0,   0,  8177 - (8177 % 16) + T_S + 1, 12}, // R12 collision
      '{1'b0, 0,    5000, 0,   0,  5000 + (T_S - 4096) + 1,      9},  // R9 stop
      '{1'b0, 0,    0,    100, 50, 100 + T_S + 1,                10}  // R10 internal reset, R8 read
   };

   logic       clk = 1'b0;
   logic       por, irst, stp, dis, rate, svc, rd;
   logic [7:0] rd_data;
   logic       rst, cause;
   int         cyc = 0;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdog_chain #(
      .PRE_W(PRE_W), .LOW_KEEP(LOW_KEEP), .WD_W(WD_W), .SHORT_BITS(SHORT_BITS),
      .PULSE_LEN(PULSE_LEN), .POR_DLY(POR_DLY), .DATA_W(8), .VEC_LO(VEC)
   ) i_wdog_chain (
      .clk_i(clk), .por_i(por), .int_rst_i(irst), .stop_i(stp), .test_dis_i(dis),
      .rate_long_i(rate), .svc_wr_i(svc), .ctl_rd_i(rd),
      .rd_data_o(rd_data), .rst_o(rst), .cause_o(cause)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_to_rise(input int anchor, input int svc_m, input int stp_m,
                              input int irst_m, input int rd_m, output int rise_at);
      int guard = 0;
      int off;
      rise_at = -1;
      while (rise_at < 0 && guard < 70000) begin
         off  = cyc - anchor + 1;
         svc  = (off == svc_m);
         stp  = (off == stp_m);
         irst = (off == irst_m);
         rd   = (off == rd_m);
         #1;
         if (rd) chk(rd_data == VEC, "R8 read data", int'(rd_data), int'(VEC));
         @(posedge clk);
         #1;
         guard++;
         if (rst) rise_at = cyc;
      end
      svc = 0; stp = 0; irst = 0; rd = 0;
   endtask

   task automatic measure_pulse(input int rise_at, output int end_at);
      int guard = 0;
      while (rst && guard < 200) begin
         tick();
         guard++;
      end
      end_at = cyc;
      chk(end_at - rise_at == PULSE_LEN, "R6 pulse width", end_at - rise_at, PULSE_LEN);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R3 watchdog expired: cycle %0d expected below %0d", cyc, 195000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int a;
      int r;
      int anchor;
      int viol;
      por = 1; irst = 0; stp = 0; dis = 0; rate = 0; svc = 0; rd = 0;
      repeat (3) tick();
      chk(rst == 0, "R1 rst in reset", int'(rst), 0);
      chk(cause == 0, "R1 cause in reset", int'(cause), 0);
      chk(rd_data == 0, "R8 idle read data", int'(rd_data), 0);

      // R2: power-on window then short timeout
      por = 0;
      a = cyc;
      run_to_rise(a, 0, 0, 0, 0, r);
      chk(r - a == POR_DLY + T_S + 1, "R2 first timeout after power-on", r - a, POR_DLY + T_S + 1);
      chk(cause == 1, "R7 cause set", int'(cause), 1);
      measure_pulse(r, anchor);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         rate = VECS[i].rate;
         run_to_rise(anchor, VECS[i].svc, VECS[i].stp, VECS[i].irst, VECS[i].rd, r);
         chk(r - anchor == VECS[i].expd, $sformatf("R%0d case %0d timeout", VECS[i].rq, i),
             r - anchor, VECS[i].expd);
         chk(cause == 1, $sformatf("R7 cause sticky case %0d", i), int'(cause), 1);
         measure_pulse(r, anchor);
      end
      rate = 0;

      // R11: disable blocks the reset past the short terminal count
      dis = 1;
      viol = 0;
      repeat (8400) begin
         tick();
         if (rst) viol++;
      end
      chk(viol == 0, "R11 reset while disabled", viol, 0);
      chk(rd_data == 0, "R8 idle read data", int'(rd_data), 0);

      // R7/R1: only power-on clears the cause flag
      dis = 0;
      por = 1;
      tick();
      tick();
      chk(cause == 0, "R7 cause cleared by power-on", int'(cause), 0);
      chk(rst == 0, "R1 rst after power-on", int'(rst), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule